// File: doc/BRIEF.md
# Prioritized Two-Class Interrupt Controller

This block gathers up to 32 interrupt request lines, records them in a pending register and lets software block any of them with a mask register. Each source has a small configuration word. The word gives the source a 5-bit urgency, sends it to either the normal-interrupt class (IRQ) or the fast-interrupt class (FIQ), and sets whether the line is edge-sensed or level-sensed. Two independent arbiters look at the pending, unmasked sources of their own class and each picks one winner. Each class drives its own registered output line to the processor.

Software reads the winning source number of a class from a dedicated register. That read also acknowledges the source: an edge-sensed winner loses its pending bit, while a level-sensed winner stays pending for as long as its line is held. Software can also clear pending bits by AND-writing the pending register, and it can raise edge-sensed sources through a write-only set register. The register port is a simple single-beat 32-bit word bus with a response one cycle later.

Top module: `prio_intc`

## Requirements
- R1: A low-to-high transition on a request input sets that source's pending bit at the next clock edge, whatever its sensing mode. Pending bit n is bit n of the register at byte offset 0x00.
- R2: For a level-sensed source, pending clears while its input is low. For an edge-sensed source, pending stays set after the input falls, until software clears or acknowledges it.
- R3: A write to offset 0x00 ANDs the written value into pending: a 0 bit clears that source and a 1 bit leaves it unchanged.
- R4: The mask register at offset 0x04 reads back all 32 written bits. A source whose mask bit is 1 takes no part in either arbitration and cannot drive an output.
- R5: The configuration word of source n sits at offset 0x1C + 4*n and keeps only bits 6:0. Bit 0 = 1 selects FIQ and 0 selects IRQ. Bit 1 = 1 selects level sensing and 0 selects edge sensing. Bits 6:2 hold the urgency, and a larger value wins.
- R6: Within each class, the candidate with the largest urgency wins. On equal urgency the lowest source number wins. The two classes are arbitrated independently.
- R7: `irq_o` and `fiq_o` are registered. Each is 1 exactly one clock after its class has at least one pending, unmasked candidate.
- R8: A read of offset 0x10 returns the IRQ winner number and a read of 0x14 returns the FIQ winner number. Either returns 0xF000000F when its class has no candidate.
- R9: A read of a winner-number register that returns a source clears that source's pending bit only if the source is edge-sensed.
- R10: A write to offset 0x9C sets the pending bit of every edge-sensed source whose data bit is 1. Level-sensed sources are untouched, and reads of 0x9C return 0.
- R11: Offset 0x18 accepts writes with no effect and reads as 0.
- R12: Writes to 0x10 or 0x14, offsets outside the map, byte addresses not aligned to a word, and accesses whose byte enables are not all four set get an error response. They have no effect on any register.
- R13: After reset, pending and mask are 0, every urgency is 0, every source is routed to IRQ, and the sensing mode of source n is bit n of parameter `LEVEL_RESET` (1 = level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Raw interrupt request lines |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_be | input | 4 | Byte enables; must be 4'hF |
| bus_wdata | input | 32 | Write data |
| bus_rsp_vld | output | 1 | Response valid, one cycle after bus_req |
| bus_rdata | output | 32 | Read data (0 on writes and errors) |
| bus_err | output | 1 | Error response |
| irq_o | output | 1 | Normal-class interrupt output |
| fiq_o | output | 1 | Fast-class interrupt output |

## Verification
The hardest state to reach from the ports has several sources pending at once with equal urgency in one class and a different source in the other class. Only then do the tie-break and the class separation show up. The bench reaches it by programming the configuration words first and then raising four edge-sensed sources in a single software-set write. It then drains the winners one acknowledge read at a time, expecting ascending source numbers within each urgency and finally the no-candidate code.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

   localparam int PRIO_W   = 5;
   localparam int CFG_BITS = 7;
   localparam logic [31:0] NONE_CODE = 32'hF000_000F;

   // Word indices (byte offset / 4) of the register map
   localparam int W_PEND   = 0;
   localparam int W_MASK   = 1;
   localparam int W_IRQNUM = 4;
   localparam int W_FIQNUM = 5;
   localparam int W_AGREE  = 6;
   localparam int W_CFG0   = 7;
   localparam int W_SWSET  = 39;

   typedef struct packed {
      logic [PRIO_W-1:0] prio;
      logic              level;
      logic              fast;
   } src_cfg_t;

   typedef enum logic [2:0] {
      SEL_PEND, SEL_MASK, SEL_IRQNUM, SEL_FIQNUM,
      SEL_AGREE, SEL_CFG, SEL_SWSET, SEL_BAD
   } reg_sel_e;

endpackage

// File: rtl/prio_intc_pend.sv
module prio_intc_pend #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_i,
   input  logic [N-1:0] level,
   input  logic [N-1:0] sw_clr,
   input  logic [N-1:0] ack_clr,
   input  logic [N-1:0] sw_set,
   output logic [N-1:0] pend
);

   logic [N-1:0] src_q;
   logic [N-1:0] rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_i;
   end

   assign rise = src_i & ~src_q;

   for (genvar n = 0; n < N; n++) begin : g_bit
      logic keep, set_now;
      assign keep    = pend[n] & ~sw_clr[n] & ~ack_clr[n] & ~(level[n] & ~src_i[n]);
      assign set_now = rise[n] | (sw_set[n] & ~level[n]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend[n] <= 1'b0;
         else        pend[n] <= keep | set_now;
      end

      assert_rise_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (src_i[n] && !src_q[n]) |=> pend[n]);

      assert_level_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (level[n] && !src_i[n]) |=> !pend[n]);

      assert_edge_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!level[n] && pend[n] && !sw_clr[n] && !ack_clr[n]) |=> pend[n]);
   end

endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb #(
   parameter int N  = 32,
   parameter int PW = 5,
   localparam int IW = $clog2(N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         cand,
   input  logic [N-1:0][PW-1:0] prio,
   output logic                 vld,
   output logic [IW-1:0]        idx
);

   logic [PW-1:0] best;

   // Linear scan: strict compare keeps the lowest index on a tie
   always_comb begin
      vld  = 1'b0;
      idx  = '0;
      best = '0;
      for (int i = 0; i < N; i++) begin
         if (cand[i] && (!vld || prio[i] > best)) begin
            vld  = 1'b1;
            idx  = IW'(i);
            best = prio[i];
         end
      end
   end

   assert_winner_is_cand_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> cand[idx]);

   assert_empty_no_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cand == '0) |-> !vld);

endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import prio_intc_pkg::*;
#(
   parameter int          NUM_SRC     = 32,
   parameter int          ADDR_W      = 8,
   parameter logic [31:0] LEVEL_RESET = 32'hFFFF_FFFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_req,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [3:0]         bus_be,
   input  logic [31:0]        bus_wdata,
   output logic               bus_rsp_vld,
   output logic [31:0]        bus_rdata,
   output logic               bus_err,
   output logic               irq_o,
   output logic               fiq_o
);

   localparam int IW = $clog2(NUM_SRC);
   localparam int WW = ADDR_W - 2;

   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_num
      $error("prio_intc: NUM_SRC must lie in 2..32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("prio_intc: ADDR_W must be at least 8");
   end

   // ---------------- state ----------------
   src_cfg_t             cfg_q [NUM_SRC];
   logic [31:0]          mask_q;
   logic [NUM_SRC-1:0]   pend;
   logic [NUM_SRC-1:0]   level_v, fast_v;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_v;

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_cfg_view
      assign level_v[n] = cfg_q[n].level;
      assign fast_v[n]  = cfg_q[n].fast;
      assign prio_v[n]  = cfg_q[n].prio;
   end

   // ---------------- decode ----------------
   logic [WW-1:0] word;
   reg_sel_e      sel;
   logic [IW-1:0] cfg_idx;
   logic          acc_err, acc_ok;

   assign word = bus_addr[ADDR_W-1:2];

   always_comb begin
      int w;
      w       = int'(word);
      cfg_idx = IW'(w - W_CFG0);
      if      (w == W_PEND)   sel = SEL_PEND;
      else if (w == W_MASK)   sel = SEL_MASK;
      else if (w == W_IRQNUM) sel = SEL_IRQNUM;
      else if (w == W_FIQNUM) sel = SEL_FIQNUM;
      else if (w == W_AGREE)  sel = SEL_AGREE;
      else if (w >= W_CFG0 && w < W_CFG0 + NUM_SRC) sel = SEL_CFG;
      else if (w == W_SWSET)  sel = SEL_SWSET;
      else                    sel = SEL_BAD;
   end

   assign acc_err = (bus_be != 4'hF) || (bus_addr[1:0] != 2'b00) || (sel == SEL_BAD) ||
                    (bus_we && (sel == SEL_IRQNUM || sel == SEL_FIQNUM));
   assign acc_ok  = bus_req && !acc_err;

   // ---------------- arbitration ----------------
   logic [1:0]          win_vld;
   logic [1:0][IW-1:0]  win_idx;
   logic [NUM_SRC-1:0]  live;

   assign live = pend & ~mask_q[NUM_SRC-1:0];

   for (genvar c = 0; c < 2; c++) begin : g_class
      logic [NUM_SRC-1:0] cand;
      assign cand = live & ((c == 1) ? fast_v : ~fast_v);

      prio_intc_arb #(.N(NUM_SRC), .PW(PRIO_W)) u_arb (
         .clk  (clk),
         .rst_n(rst_n),
         .cand (cand),
         .prio (prio_v),
         .vld  (win_vld[c]),
         .idx  (win_idx[c])
      );
   end

   // ---------------- pending control ----------------
   logic               rd_irqnum, rd_fiqnum;
   logic [NUM_SRC-1:0] sw_clr, sw_set, ack_clr;

   assign rd_irqnum = acc_ok && !bus_we && (sel == SEL_IRQNUM);
   assign rd_fiqnum = acc_ok && !bus_we && (sel == SEL_FIQNUM);
   assign sw_clr    = (acc_ok && bus_we && sel == SEL_PEND)  ? ~bus_wdata[NUM_SRC-1:0] : '0;
   assign sw_set    = (acc_ok && bus_we && sel == SEL_SWSET) ?  bus_wdata[NUM_SRC-1:0] : '0;

   always_comb begin
      ack_clr = '0;
      if (rd_irqnum && win_vld[0] && !level_v[win_idx[0]]) ack_clr[win_idx[0]] = 1'b1;
      if (rd_fiqnum && win_vld[1] && !level_v[win_idx[1]]) ack_clr[win_idx[1]] = 1'b1;
   end

   prio_intc_pend #(.N(NUM_SRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i),
      .level  (level_v),
      .sw_clr (sw_clr),
      .ack_clr(ack_clr),
      .sw_set (sw_set),
      .pend   (pend)
   );

   // ---------------- register writes ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         for (int n = 0; n < NUM_SRC; n++)
            cfg_q[n] <= '{prio: '0, level: LEVEL_RESET[n], fast: 1'b0};
      end else if (acc_ok && bus_we) begin
         if (sel == SEL_MASK) mask_q <= bus_wdata;
         for (int n = 0; n < NUM_SRC; n++)
            if (sel == SEL_CFG && cfg_idx == IW'(n))
               cfg_q[n] <= src_cfg_t'(bus_wdata[CFG_BITS-1:0]);
      end
   end

   // ---------------- read mux and response ----------------
   logic [31:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_PEND:   rd_mux = 32'(pend);
         SEL_MASK:   rd_mux = mask_q;
         SEL_IRQNUM: rd_mux = win_vld[0] ? 32'(win_idx[0]) : NONE_CODE;
         SEL_FIQNUM: rd_mux = win_vld[1] ? 32'(win_idx[1]) : NONE_CODE;
         SEL_CFG:    rd_mux = 32'(cfg_q[cfg_idx]);
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rsp_vld <= 1'b0;
         bus_rdata   <= '0;
         bus_err     <= 1'b0;
         irq_o       <= 1'b0;
         fiq_o       <= 1'b0;
      end else begin
         bus_rsp_vld <= bus_req;
         bus_err     <= bus_req && acc_err;
         bus_rdata   <= (acc_ok && !bus_we) ? rd_mux : '0;
         irq_o       <= win_vld[0];
         fiq_o       <= win_vld[1];
      end
   end

   assert_err_no_effect_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rsp_vld && bus_err) |-> (mask_q == $past(mask_q)));

   assert_irq_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(pend & ~mask_q[NUM_SRC-1:0] & ~fast_v) != '0));

   assert_fiq_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> ($past(pend & ~mask_q[NUM_SRC-1:0] & fast_v) != '0));

endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;

   localparam logic [31:0] NONE = 32'hF000_000F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = 4'hF;
   logic [31:0] bus_wdata = '0;
   logic        bus_rsp_vld, bus_err, irq_o, fiq_o;
   logic [31:0] bus_rdata;

   int checks = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   // sources 4..7 reset edge-sensed, all others level-sensed
   prio_intc #(.NUM_SRC(32), .ADDR_W(8), .LEVEL_RESET(32'hFFFF_FF0F)) dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .bus_rsp_vld(bus_rsp_vld), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .irq_o(irq_o), .fiq_o(fiq_o));

   typedef struct packed {
      logic [23:0] tag;
      logic        we;
      logic [7:0]  addr;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic [31:0] exp;
      logic        exp_err;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{"R13", 1'b0, 8'h00, 4'hF, 32'h0,         32'h0,         1'b0},
      '{"R13", 1'b0, 8'h04, 4'hF, 32'h0,         32'h0,         1'b0},
      '{"R13", 1'b0, 8'h1C, 4'hF, 32'h0,         32'h2,         1'b0},
      '{"R13", 1'b0, 8'h2C, 4'hF, 32'h0,         32'h0,         1'b0},
      '{"R4 ", 1'b1, 8'h04, 4'hF, 32'hA5A5_0000, 32'h0,         1'b0},
      '{"R4 ", 1'b0, 8'h04, 4'hF, 32'h0,         32'hA5A5_0000, 1'b0},
      '{"R4 ", 1'b1, 8'h04, 4'hF, 32'h0,         32'h0,         1'b0},
      '{"R5 ", 1'b1, 8'h20, 4'hF, 32'hFFFF_FFFF, 32'h0,         1'b0},
      '{"R5 ", 1'b0, 8'h20, 4'hF, 32'h0,         32'h7F,        1'b0},
      '{"R8 ", 1'b0, 8'h10, 4'hF, 32'h0,         NONE,          1'b0},
      '{"R8 ", 1'b0, 8'h14, 4'hF, 32'h0,         NONE,          1'b0},
      '{"R11", 1'b1, 8'h18, 4'hF, 32'hFFFF_FFFF, 32'h0,         1'b0},
      '{"R11", 1'b0, 8'h18, 4'hF, 32'h0,         32'h0,         1'b0},
      '{"R10", 1'b0, 8'h9C, 4'hF, 32'h0,         32'h0,         1'b0},
      '{"R12", 1'b1, 8'h10, 4'hF, 32'h5,         32'h0,         1'b1},
      '{"R12", 1'b0, 8'hA0, 4'hF, 32'h0,         32'h0,         1'b1},
      '{"R12", 1'b0, 8'h00, 4'h3, 32'h0,         32'h0,         1'b1},
      '{"R12", 1'b0, 8'h02, 4'hF, 32'h0,         32'h0,         1'b1},
      '{"R5 ", 1'b1, 8'h20, 4'hF, 32'h2,         32'h0,         1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus(input logic we, input logic [7:0] addr, input logic [3:0] be,
                      input logic [31:0] wdata, output logic [31:0] rdata, output logic err);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_be = be; bus_wdata = wdata;
      @(negedge clk);
      rdata = bus_rdata;
      err   = bus_err | ~bus_rsp_vld;
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic wr(input logic [7:0] addr, input logic [31:0] d);
      logic [31:0] r; logic e;
      bus(1'b1, addr, 4'hF, d, r, e);
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] addr, input logic [31:0] exp);
      logic [31:0] r; logic e;
      bus(1'b0, addr, 4'hF, 32'h0, r, e);
      check(tag, {31'h0, e}, 32'h0);
      check(tag, r, exp);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] r; logic e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 / R7 reset outputs
      check("R13 irq_o", {31'h0, irq_o}, 32'h0);
      check("R13 fiq_o", {31'h0, fiq_o}, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         bus(VEC[i].we, VEC[i].addr, VEC[i].be, VEC[i].wdata, r, e);
         check(string'(VEC[i].tag), {31'h0, e}, {31'h0, VEC[i].exp_err});
         if (!VEC[i].we && !VEC[i].exp_err) check(string'(VEC[i].tag), r, VEC[i].exp);
      end

      // R1 R7 R9: level source 2, urgency 3, IRQ
      wr(8'h24, 32'h0E);
      @(negedge clk); src_i[2] = 1'b1;
      @(negedge clk);
      check("R7 latency low", {31'h0, irq_o}, 32'h0);
      @(negedge clk);
      check("R7 irq high", {31'h0, irq_o}, 32'h1);
      check("R7 fiq low", {31'h0, fiq_o}, 32'h0);
      rd_chk("R1 pend", 8'h00, 32'h4);
      rd_chk("R8 irq num", 8'h10, 32'h2);
      rd_chk("R9 level stays", 8'h00, 32'h4);
      // R2 level drop
      src_i[2] = 1'b0;
      rd_chk("R2 level clear", 8'h00, 32'h0);
      @(negedge clk);
      check("R2 irq low", {31'h0, irq_o}, 32'h0);

      // R2 R9 edge source 4
      @(negedge clk); src_i[4] = 1'b1;
      @(negedge clk); src_i[4] = 1'b0;
      rd_chk("R2 edge holds", 8'h00, 32'h10);
      rd_chk("R8 edge num", 8'h10, 32'h4);
      rd_chk("R9 edge acked", 8'h00, 32'h0);

      // R6 arbitration and class split
      wr(8'h30, 32'h1C);              // src5 urgency 7 IRQ edge
      wr(8'h34, 32'h1C);              // src6 urgency 7 IRQ edge
      wr(8'h38, 32'h25);              // src7 urgency 9 FIQ edge
      wr(8'h9C, 32'h0000_00F1);       // bit0 is a level source
      rd_chk("R10 swset", 8'h00, 32'hF0);
      check("R7 irq on", {31'h0, irq_o}, 32'h1);
      check("R7 fiq on", {31'h0, fiq_o}, 32'h1);
      rd_chk("R6 fiq winner", 8'h14, 32'h7);
      rd_chk("R6 tie low idx", 8'h10, 32'h5);
      rd_chk("R6 next", 8'h10, 32'h6);
      rd_chk("R6 low prio", 8'h10, 32'h4);
      rd_chk("R8 drained irq", 8'h10, NONE);
      rd_chk("R8 drained fiq", 8'h14, NONE);
      @(negedge clk);
      check("R7 irq off", {31'h0, irq_o}, 32'h0);
      check("R7 fiq off", {31'h0, fiq_o}, 32'h0);

      // R4 mask
      wr(8'h04, 32'h20);
      wr(8'h9C, 32'h20);
      rd_chk("R4 masked none", 8'h10, NONE);
      check("R4 irq masked", {31'h0, irq_o}, 32'h0);
      wr(8'h04, 32'h0);
      @(negedge clk);
      check("R4 irq unmasked", {31'h0, irq_o}, 32'h1);

      // R3 AND write
      wr(8'h9C, 32'h10);
      rd_chk("R3 before", 8'h00, 32'h30);
      wr(8'h00, 32'hFFFF_FFEF);
      rd_chk("R3 and clear", 8'h00, 32'h20);
      wr(8'h00, 32'h0);
      rd_chk("R3 all clear", 8'h00, 32'h0);

      // R12 partial write leaves mask untouched
      bus(1'b1, 8'h04, 4'h3, 32'hFFFF_FFFF, r, e);
      check("R12 err", {31'h0, e}, 32'h1);
      rd_chk("R12 mask kept", 8'h04, 32'h0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule